// File: doc/BRIEF.md
# Masked-Policy Control/Status Register Bank

This block holds a small set of 32-bit control/status registers and serves them over a memory-mapped request port. Each register is placed by a compile-time table. The table gives its byte address, its value after reset, and five per-bit policy masks: read-only, write-one-to-clear, clear-on-read, reserved and unimplemented. Each bit follows its own policy. A single software write can load the plain read/write bits, leave the read-only and reserved bits unchanged, and clear the selected write-one-to-clear bits, all in the same cycle.

Each request carries an address, write data, a size code and a direction. The size code sets the byte enables. The enabled bytes are the low N bytes, where N is the smaller of the access size and the 4-byte register width. Hardware-side logic can raise event bits through a per-register set vector. Three one-cycle diagnostic pulses report an access to an unmapped address, a write that changes a reserved bit, and a write that sets an unimplemented bit.

The request side follows valid/ready. `req_ready` is low while reset is asserted and during the first clock after it is released. After that it stays high, so the block never stalls a request. A request is taken on any clock edge where both `req_valid` and `req_ready` are high. The response side has no ready signal and cannot be back-pressured. Each accepted read produces exactly one `rsp_valid` beat on the following clock. A write produces no response beat.

Top module: `csr_bank`

## Requirements
- R1: When reset is released, every register holds its own reset value. With the default table these are 0x5A0000A5 at 0x00, 0x00000000 at 0x04, 0x12340000 at 0x08 and 0xDEADBEEF at 0x10.
- R2: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. The enable mask covers the low min(bytes, 4) bytes. A write loads enabled read/write bits from `req_wdata` and leaves every bit outside the enable mask unchanged.
- R3: A write never changes read-only bits or reserved bits.
- R4: After the merge, every bit that is set in `req_wdata` and also marked write-one-to-clear becomes 0. A write-one-to-clear bit written with 0 keeps its value.
- R5: An accepted read raises `rsp_valid` on the next clock. `rsp_rdata` then carries the register contents ANDed with the enable mask.
- R6: A read clears the clear-on-read bits that lie inside its enable mask. The value it returns is the value from before the clear.
- R7: A write to an address that maps no register changes nothing. A read from such an address returns 0. Either access pulses `err_unmapped` on the next clock, alone among the three diagnostic flags.
- R8: `err_rsvd` pulses on the clock after a mapped write whose data differs from the stored value in any reserved bit. This does not depend on the enable mask, and the write still completes.
- R9: `err_unimp` pulses on the clock after a mapped write whose data has any unimplemented bit set. This does not depend on the enable mask, and the write still completes.
- R10: A bit of `hw_set` sets the matching stored bit only where that bit is write-one-to-clear or clear-on-read. A hardware set beats a software clear of the same bit in the same cycle.
- R11: `req_ready` is high from the second clock after reset release onward. Only accepted reads produce `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size code (0..3 = 1, 2, 4, 8 bytes) |
| req_wdata | input | 32 | Write data |
| hw_set | input | NREG*32 | Hardware event set bits, register i at bits [32*i +: 32] |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| err_unmapped | output | 1 | Pulse: access to an unmapped address |
| err_rsvd | output | 1 | Pulse: write changed reserved bits |
| err_unimp | output | 1 | Pulse: write set unimplemented bits |

## Verification
The bench builds the block with its default table of four registers. Each register carries a different policy: read-only byte plus reserved and unimplemented fields, write-one-to-clear events, clear-on-read counters, and plain read/write. Together they cover every mask in one compact map. The hole at 0x0C sits between mapped words, so unmapped accesses are tested inside the decoded range and not only past its end. The 8-byte size code brings the clamping of the enable mask to the register width within reach.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int WORD_W  = 32;
  localparam int WORD_BY = WORD_W / 8;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {SZ_1B = 2'd0, SZ_2B = 2'd1, SZ_4B = 2'd2, SZ_8B = 2'd3} size_e;

  // Byte lanes enabled by an access: the low min(access bytes, register bytes).
  function automatic word_t lane_mask(input logic [1:0] sz);
    int    nbytes;
    word_t m;
    nbytes = 1 << sz;
    if (nbytes > WORD_BY) nbytes = WORD_BY;
    m = '0;
    for (int b = 0; b < WORD_BY; b++)
      if (b < nbytes) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction
endpackage

// File: rtl/csr_decode.sv
module csr_decode #(
  parameter int NREG = 4,
  parameter int ADDR_W = 8,
  parameter logic [NREG*ADDR_W-1:0] REG_ADDRS = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit_vec,
  output logic              any_hit
);
  always_comb begin
    for (int i = 0; i < NREG; i++)
      hit_vec[i] = (addr == REG_ADDRS[i*ADDR_W +: ADDR_W]);
    any_hit = |hit_vec;
  end
endmodule

// File: rtl/csr_reg_slice.sv
module csr_reg_slice
  import csr_pkg::*;
#(
  parameter word_t RST_VAL    = '0,
  parameter word_t RO_MASK    = '0,
  parameter word_t W1C_MASK   = '0,
  parameter word_t COR_MASK   = '0,
  parameter word_t RSVD_MASK  = '0,
  parameter word_t UNIMP_MASK = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  logic  rd_en,
  input  word_t wdata,
  input  word_t en_mask,
  input  word_t hw_set,
  output word_t q,
  output logic  rsvd_hit,
  output logic  unimp_hit
);
  // Bits that software data never loads directly.
  localparam word_t FIXED_BITS = RO_MASK | W1C_MASK | RSVD_MASK;
  // Bits hardware events may raise.
  localparam word_t EVENT_BITS = W1C_MASK | COR_MASK;

  word_t guard, merged, next_q;

  always_comb begin
    guard  = FIXED_BITS | ~en_mask;
    merged = (wdata & ~guard) | (q & guard);
    merged = merged & ~(wdata & W1C_MASK);
    next_q = q;
    if (wr_en)      next_q = merged;
    else if (rd_en) next_q = q & ~(COR_MASK & en_mask);
    next_q = next_q | (hw_set & EVENT_BITS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= next_q;
  end

  assign rsvd_hit  = wr_en && (((q ^ wdata) & RSVD_MASK) != '0);
  assign unimp_hit = wr_en && ((wdata & UNIMP_MASK) != '0);
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int ADDR_W = 8,
  parameter logic [NREG*ADDR_W-1:0] REG_ADDRS  = {8'h10, 8'h08, 8'h04, 8'h00},
  parameter logic [NREG*32-1:0]     RST_VALS   = {32'hDEADBEEF, 32'h12340000, 32'h00000000, 32'h5A0000A5},
  parameter logic [NREG*32-1:0]     RO_MASKS   = {32'h00000000, 32'hFFFF0000, 32'hFFFF0000, 32'hFF000000},
  parameter logic [NREG*32-1:0]     W1C_MASKS  = {32'h00000000, 32'h00000000, 32'h000000FF, 32'h00000000},
  parameter logic [NREG*32-1:0]     COR_MASKS  = {32'h00000000, 32'h0000FFFF, 32'h00000000, 32'h00000000},
  parameter logic [NREG*32-1:0]     RSVD_MASKS = {32'h00000000, 32'h00000000, 32'h00000000, 32'h00F00000},
  parameter logic [NREG*32-1:0]     UNIMP_MASKS= {32'h00000000, 32'h00000000, 32'h00000000, 32'h000F0000}
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [31:0]          req_wdata,
  input  logic [NREG*32-1:0]   hw_set,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic                 err_unmapped,
  output logic                 err_rsvd,
  output logic                 err_unimp
);
  logic [NREG-1:0]    hit_vec, rsvd_vec, unimp_vec;
  logic               any_hit, ready_q, accept;
  word_t              en_mask, rd_word;
  logic [NREG*32-1:0] regs_flat;

  csr_decode #(.NREG(NREG), .ADDR_W(ADDR_W), .REG_ADDRS(REG_ADDRS)) u_dec (
    .addr(req_addr), .hit_vec(hit_vec), .any_hit(any_hit)
  );

  assign en_mask   = lane_mask(req_size);
  assign req_ready = ready_q;
  assign accept    = req_valid && ready_q;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    csr_reg_slice #(
      .RST_VAL   (RST_VALS[i*32 +: 32]),
      .RO_MASK   (RO_MASKS[i*32 +: 32]),
      .W1C_MASK  (W1C_MASKS[i*32 +: 32]),
      .COR_MASK  (COR_MASKS[i*32 +: 32]),
      .RSVD_MASK (RSVD_MASKS[i*32 +: 32]),
      .UNIMP_MASK(UNIMP_MASKS[i*32 +: 32])
    ) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (accept && req_write && hit_vec[i]),
      .rd_en    (accept && !req_write && hit_vec[i]),
      .wdata    (req_wdata),
      .en_mask  (en_mask),
      .hw_set   (hw_set[i*32 +: 32]),
      .q        (regs_flat[i*32 +: 32]),
      .rsvd_hit (rsvd_vec[i]),
      .unimp_hit(unimp_vec[i])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++)
      if (hit_vec[i]) rd_word = rd_word | regs_flat[i*32 +: 32];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q      <= 1'b0;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      err_unmapped <= 1'b0;
      err_rsvd     <= 1'b0;
      err_unimp    <= 1'b0;
    end else begin
      ready_q      <= 1'b1;
      rsp_valid    <= accept && !req_write;
      err_unmapped <= accept && !any_hit;
      err_rsvd     <= |rsvd_vec;
      err_unimp    <= |unimp_vec;
      if (accept && !req_write)
        rsp_rdata <= any_hit ? (rd_word & en_mask) : '0;
    end
  end
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk #(
  parameter int NREG = 4,
  parameter logic [NREG*32-1:0] RO_MASKS = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [1:0]         req_size,
  input logic               rsp_valid,
  input logic [31:0]        rsp_rdata,
  input logic               err_unmapped,
  input logic               err_rsvd,
  input logic               err_unimp,
  input logic [NREG*32-1:0] regs_flat
);
  // R11
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> rsp_valid);
  // R11
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && !req_write) |=> !rsp_valid);
  // R7
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && err_unmapped) |-> (rsp_rdata == 32'h0));
  // R7
  unmapped_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_unmapped |-> !(err_rsvd || err_unimp));
  // R8
  rsvd_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_rsvd |-> $past(req_valid && req_ready && req_write));
  // R9
  unimp_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_unimp |-> $past(req_valid && req_ready && req_write));
  // R5
  byte_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && req_size == 2'd0) |=> (rsp_rdata[31:8] == 24'h0));
  // R3
  ro_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs_flat & RO_MASKS));
endmodule

bind csr_bank csr_bank_chk #(.NREG(NREG), .RO_MASKS(RO_MASKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .err_unmapped(err_unmapped), .err_rsvd(err_rsvd),
  .err_unimp(err_unimp), .regs_flat(regs_flat)
);

// File: tb/sim_csr_bank.sv
`timescale 1ns/1ps
module sim_csr_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]   req_addr = '0;
  logic [1:0]   req_size = '0;
  logic [31:0]  req_wdata = '0;
  logic [127:0] hw_set = '0;
  logic         req_ready, rsp_valid, err_unmapped, err_rsvd, err_unimp;
  logic [31:0]  rsp_rdata;

  always #2.5 clk = ~clk;

  csr_bank u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .hw_set(hw_set), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .err_unmapped(err_unmapped), .err_rsvd(err_rsvd),
    .err_unimp(err_unimp)
  );

  // Register table as stated in the requirements.
  localparam logic [7:0]  T_ADDR [4] = '{8'h00, 8'h04, 8'h08, 8'h10};
  localparam logic [31:0] T_RST  [4] = '{32'h5A0000A5, 32'h0, 32'h12340000, 32'hDEADBEEF};
  localparam logic [31:0] T_RO   [4] = '{32'hFF000000, 32'hFFFF0000, 32'hFFFF0000, 32'h0};
  localparam logic [31:0] T_W1C  [4] = '{32'h0, 32'h000000FF, 32'h0, 32'h0};
  localparam logic [31:0] T_COR  [4] = '{32'h0, 32'h0, 32'h0000FFFF, 32'h0};
  localparam logic [31:0] T_RSVD [4] = '{32'h00F00000, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] T_UNIM [4] = '{32'h000F0000, 32'h0, 32'h0, 32'h0};

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;

  // Behavioural reference model
  logic [31:0] m_q [4];
  logic        m_ready, m_rv, m_eu, m_er, m_ei;
  logic [31:0] m_rd;

  function automatic logic [31:0] bytes_mask(input logic [1:0] sz);
    int n;
    logic [31:0] m;
    n = 1;
    for (int k = 0; k < int'(sz); k++) n = n * 2;
    if (n > 4) n = 4;
    m = 0;
    for (int b = 0; b < n; b++) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_q[i] = T_RST[i];
      m_ready = 0; m_rv = 0; m_eu = 0; m_er = 0; m_ei = 0; m_rd = 0;
    end else begin
      int          idx;
      logic [31:0] en, nv, old;
      m_rv = 0; m_eu = 0; m_er = 0; m_ei = 0;
      if (req_valid && m_ready) begin
        idx = -1;
        for (int i = 0; i < 4; i++) if (T_ADDR[i] == req_addr) idx = i;
        en = bytes_mask(req_size);
        if (idx < 0) begin
          m_eu = 1;
          if (!req_write) begin m_rv = 1; m_rd = 0; end
        end else if (req_write) begin
          old = m_q[idx];
          for (int b = 0; b < 32; b++) begin
            if (en[b] && !T_RO[idx][b] && !T_W1C[idx][b] && !T_RSVD[idx][b]) nv[b] = req_wdata[b];
            else nv[b] = old[b];
            if (T_W1C[idx][b] && req_wdata[b]) nv[b] = 1'b0;
          end
          m_er = ((old ^ req_wdata) & T_RSVD[idx]) != 0;
          m_ei = (req_wdata & T_UNIM[idx]) != 0;
          m_q[idx] = nv;
        end else begin
          m_rv = 1;
          m_rd = m_q[idx] & en;
          m_q[idx] = m_q[idx] & ~(T_COR[idx] & en);
        end
      end
      for (int i = 0; i < 4; i++) m_q[i] = m_q[i] | (hw_set[i*32 +: 32] & (T_W1C[i] | T_COR[i]));
      m_ready = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare outputs with the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      check(req_ready == m_ready, cur_req, "req_ready", 32'(req_ready), 32'(m_ready));
      check(rsp_valid == m_rv, cur_req, "rsp_valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) check(rsp_rdata == m_rd, cur_req, "rsp_rdata", rsp_rdata, m_rd);
      check(err_unmapped == m_eu, cur_req, "err_unmapped", 32'(err_unmapped), 32'(m_eu));
      check(err_rsvd == m_er, cur_req, "err_rsvd", 32'(err_rsvd), 32'(m_er));
      check(err_unimp == m_ei, cur_req, "err_unimp", 32'(err_unimp), 32'(m_ei));
    end
  end

  task automatic do_write(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d,
                          input logic [31:0] hw, input int hw_idx, input string tag);
    @(negedge clk);
    cur_req = tag;
    req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = d;
    hw_set = '0; hw_set[hw_idx*32 +: 32] = hw;
    @(negedge clk);
    req_valid = 0; hw_set = '0;
    check(rsp_valid == 1'b0, "R11", "write rsp_valid", 32'(rsp_valid), 32'h0);
  endtask

  task automatic do_read(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] exp,
                         input logic [31:0] hw, input int hw_idx, input string tag);
    @(negedge clk);
    cur_req = tag;
    req_valid = 1; req_write = 0; req_addr = a; req_size = sz; req_wdata = '0;
    hw_set = '0; hw_set[hw_idx*32 +: 32] = hw;
    @(negedge clk);
    req_valid = 0; hw_set = '0;
    check(rsp_valid == 1'b1, tag, "read rsp_valid", 32'(rsp_valid), 32'h1);
    check(rsp_rdata == exp, tag, "read data", rsp_rdata, exp);
  endtask

  task automatic flags(input bit eu, input bit er, input bit ei, input string tag);
    check({err_unmapped, err_rsvd, err_unimp} == {eu, er, ei}, tag, "flags u/r/i",
          32'({err_unmapped, err_rsvd, err_unimp}), 32'({eu, er, ei}));
  endtask

  task automatic do_hw(input int idx, input logic [31:0] v, input string tag);
    @(negedge clk);
    cur_req = tag;
    hw_set = '0; hw_set[idx*32 +: 32] = v;
    @(negedge clk);
    hw_set = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    repeat (2) @(negedge clk);
    check(req_ready == 1'b1, "R11", "ready after reset", 32'(req_ready), 32'h1);

    // R1 reset contents
    do_read(8'h00, 2'd2, 32'h5A0000A5, 0, 0, "R1");
    do_read(8'h04, 2'd2, 32'h00000000, 0, 0, "R1");
    do_read(8'h08, 2'd2, 32'h12340000, 0, 0, "R1");
    do_read(8'h10, 2'd2, 32'hDEADBEEF, 0, 0, "R1");

    // R2 byte-lane enables on plain RW register
    do_write(8'h10, 2'd0, 32'h11223344, 0, 0, "R2");
    do_read (8'h10, 2'd2, 32'hDEADBE44, 0, 0, "R2");
    do_write(8'h10, 2'd1, 32'hAAAA5566, 0, 0, "R2");
    do_read (8'h10, 2'd2, 32'hDEAD5566, 0, 0, "R2");
    do_write(8'h10, 2'd3, 32'h01020304, 0, 0, "R2");
    do_read (8'h10, 2'd2, 32'h01020304, 0, 0, "R2");
    // R5 read masking
    do_read (8'h10, 2'd0, 32'h00000004, 0, 0, "R5");
    do_read (8'h10, 2'd1, 32'h00000304, 0, 0, "R5");
    do_read (8'h10, 2'd3, 32'h01020304, 0, 0, "R5");

    // R3, R8, R9 on the control register
    do_write(8'h00, 2'd2, 32'hFFFFFFFF, 0, 0, "R8");
    flags(0, 1, 1, "R8");
    do_read (8'h00, 2'd2, 32'h5A0FFFFF, 0, 0, "R3");
    do_write(8'h00, 2'd2, 32'h00000001, 0, 0, "R9");
    flags(0, 0, 0, "R9");
    do_read (8'h00, 2'd2, 32'h5A000001, 0, 0, "R3");
    do_write(8'h00, 2'd0, 32'h000F0000, 0, 0, "R9");
    flags(0, 0, 1, "R9");
    do_read (8'h00, 2'd2, 32'h5A000000, 0, 0, "R9");
    do_write(8'h00, 2'd0, 32'h00100000, 0, 0, "R8");
    flags(0, 1, 0, "R8");
    do_read (8'h00, 2'd2, 32'h5A000000, 0, 0, "R8");

    // R10, R4 on the event register
    do_hw(1, 32'hFFFFFFF3, "R10");
    do_read (8'h04, 2'd2, 32'h000000F3, 0, 0, "R10");
    do_write(8'h04, 2'd0, 32'h00000A01, 0, 0, "R4");
    do_read (8'h04, 2'd2, 32'h000000F2, 0, 0, "R4");
    do_write(8'h04, 2'd2, 32'h00003330, 0, 0, "R4");
    do_read (8'h04, 2'd2, 32'h000033C2, 0, 0, "R4");
    do_write(8'h04, 2'd0, 32'h00000041, 32'h00000001, 1, "R10");
    do_read (8'h04, 2'd2, 32'h00003383, 0, 0, "R10");
    do_write(8'h04, 2'd2, 32'hFFFF0000, 0, 0, "R3");
    do_read (8'h04, 2'd2, 32'h00000083, 0, 0, "R3");

    // R6 clear-on-read
    do_hw(2, 32'hFFFFA5A5, "R6");
    do_read (8'h08, 2'd0, 32'h000000A5, 0, 0, "R6");
    do_read (8'h08, 2'd2, 32'h1234A500, 0, 0, "R6");
    do_read (8'h08, 2'd2, 32'h12340000, 0, 0, "R6");
    do_read (8'h08, 2'd2, 32'h12340000, 32'h00000001, 2, "R10");
    do_read (8'h08, 2'd2, 32'h12340001, 0, 0, "R10");

    // R7 unmapped hole
    do_write(8'h0C, 2'd2, 32'hFFFFFFFF, 0, 0, "R7");
    flags(1, 0, 0, "R7");
    do_read (8'h0C, 2'd2, 32'h00000000, 0, 0, "R7");
    flags(1, 0, 0, "R7");
    do_read (8'h10, 2'd2, 32'h01020304, 0, 0, "R7");
    do_read (8'h00, 2'd2, 32'h5A000000, 0, 0, "R7");

    // Mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      int sel;
      @(negedge clk);
      cur_req = "R5";
      sel = int'($urandom_range(0, 5));
      req_valid = ($urandom_range(0, 3) != 0);
      req_write = $urandom_range(0, 1) == 1;
      req_addr  = (sel == 5) ? 8'h14 : (sel == 4) ? 8'h0C : T_ADDR[sel];
      req_size  = 2'($urandom_range(0, 3));
      req_wdata = $urandom;
      hw_set    = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
                   $urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
    end
    @(negedge clk);
    req_valid = 0; hw_set = '0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule